// File: doc/BRIEF.md
# BCD Countdown Watchdog with Reset/Interrupt Steering

This block is a watchdog timer whose timeout is programmed as a packed-BCD value with a resolution of one hundredth of a second. One byte register holds the hundredths, from 00 to 99. A second byte register holds whole seconds, from 00 to 99. The longest timeout is therefore 99.99 seconds. While the watchdog is enabled, an external 100 Hz tick strobe counts the value down. The clock that produces the tick is not part of the block.

When the count expires, the block sets a sticky watchdog flag and reloads itself, so it keeps running. A steering bit chooses the destination of the timeout. With the bit set, the timeout drives a fixed-length reset pulse. With it clear, the timeout raises a level interrupt. Software keeps the watchdog quiet by writing either count register, which restarts the countdown from the full programmed value. Clearing the enable stops the watchdog, and so does programming a value of zero. Reading the status register clears the flag and the interrupt.

Top module: `bcd_wdt`

## Requirements
- R1: Register map on a 4-bit address:
  - 0xC holds the hundredths and 0xD holds the seconds, each as two BCD digits (high nibble tens).
  - 0xF is the control register: bit 1 enables the watchdog and bit 0 steers a timeout to the reset output (1) or the interrupt output (0). Its other bits read as 0.
  - 0xE is the status register: bit 1 is the watchdog flag and its other bits read as 0.
  - Read data is combinational from the address in the same cycle. Reset clears all registers and both outputs.
- R2: A written nibble greater than 9 is stored as 9 in either count register.
- R3: When enabled with a programmed value of N hundredths (seconds*100 + hundredths), the watchdog times out on the Nth tick after the load. Its outputs change in the cycle after that tick.
- R4: With steering set, a timeout drives `wdt_reset` high for exactly 16 clock cycles and leaves `wdt_irq` low.
- R5: With steering clear, a timeout raises `wdt_irq`, which stays high until status is read. `wdt_reset` stays low.
- R6: Every timeout sets the flag whatever the steering. A status read returns the flag and clears the flag and the interrupt at the end of that cycle. A timeout in the same cycle as the read wins, so the flag stays set.
- R7: A write to 0xC or 0xD restarts the countdown from the full programmed value. This write is the kick.
- R8: After a timeout the counter reloads and keeps running, so the next timeout follows N ticks later.
- R9: While disabled, ticks have no effect. Writing the enable from 0 to 1 reloads the full count.
- R10: With a programmed value of 00.00, the watchdog never times out, even while enabled.
- R11: Writes to the status register 0xE have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick_100hz | input | 1 | One-cycle strobe at 100 Hz |
| host_wr | input | 1 | Register write strobe |
| host_rd | input | 1 | Register read strobe |
| host_addr | input | 4 | Register address |
| host_wdata | input | 8 | Write data |
| host_rdata | output | 8 | Read data, combinational from host_addr |
| wdt_reset | output | 1 | Reset pulse on timeout when steering is set |
| wdt_irq | output | 1 | Interrupt level on timeout when steering is clear |

## Verification
Each result falls due a set number of cycles after its stimulus.

- **Writes:** a register write takes effect at the next clock edge. Read data is valid in the cycle the address is driven.
- **Loads:** a count load, from a kick or from raising the enable, happens one edge after the write. The bench always spaces its ticks at least one cycle after that edge.
- **Timeout:** a tick seen at an edge moves the flag, the interrupt and the reset pulse at that same edge. The bench samples them at the following falling edge.
- **Reset pulse:** the bench counts the pulse one falling edge at a time and expects exactly 16 high samples.
- **Countdown:** before the final tick, the bench checks that the flag is still clear after N-1 ticks.

// File: rtl/bcd_wdt_pkg.sv
// Package: shared constants, types and helpers of the BCD watchdog.
// Assumes an 8-bit register file on a 4-bit address.
package bcd_wdt_pkg;
    localparam int ADDR_W = 4;
    localparam int DATA_W = 8;

    localparam logic [ADDR_W-1:0] ADDR_HUND = 4'hC;
    localparam logic [ADDR_W-1:0] ADDR_SECS = 4'hD;
    localparam logic [ADDR_W-1:0] ADDR_STAT = 4'hE;
    localparam logic [ADDR_W-1:0] ADDR_CTRL = 4'hF;

    localparam int CTRL_EN_BIT    = 1;
    localparam int CTRL_STEER_BIT = 0;
    localparam int STAT_FLAG_BIT  = 1;

    typedef logic [3:0] bcd_digit_t;

    // Limit a BCD nibble to the legal 0..9 range.
    function automatic bcd_digit_t clamp_digit(input logic [3:0] d);
        return (d > 4'd9) ? 4'd9 : d;
    endfunction
endpackage

// File: rtl/bcd_wdt_regs.sv
// Module: host register file of the watchdog.
// Holds the two BCD count bytes, the enable/steer control bits,
// the sticky flag and the interrupt level. Produces a registered
// load strobe one cycle after a kick or an enable rise.
// Assumes single-cycle host strobes and that fire is a one-cycle pulse.
module bcd_wdt_regs
    import bcd_wdt_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    input  logic              fire,
    output logic              en_o,
    output logic              steer_o,
    output logic [2*DATA_W-1:0] reload_o,
    output logic              load_o,
    output logic              irq_o
);
    logic [DATA_W-1:0] hund_q;
    logic [DATA_W-1:0] secs_q;
    logic              en_q;
    logic              steer_q;
    logic              flag_q;
    logic              irq_q;
    logic              load_q;
    logic [DATA_W-1:0] wdata_clamped;
    logic              wr_hund;
    logic              wr_secs;
    logic              wr_ctrl;
    logic              rd_stat;

    // Decode the host strobes per register.
    always_comb begin
        wr_hund = host_wr && (host_addr == ADDR_HUND);
        wr_secs = host_wr && (host_addr == ADDR_SECS);
        wr_ctrl = host_wr && (host_addr == ADDR_CTRL);
        rd_stat = host_rd && (host_addr == ADDR_STAT);
        wdata_clamped = {clamp_digit(host_wdata[7:4]), clamp_digit(host_wdata[3:0])};
    end

    // Store the count bytes, with each nibble limited to 9.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hund_q <= '0;
            secs_q <= '0;
        end else begin
            if (wr_hund) hund_q <= wdata_clamped;
            if (wr_secs) secs_q <= wdata_clamped;
        end
    end

    // Store the control bits and raise a load on a kick or an enable rise.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            en_q    <= 1'b0;
            steer_q <= 1'b0;
            load_q  <= 1'b0;
        end else begin
            load_q <= wr_hund || wr_secs ||
                      (wr_ctrl && host_wdata[CTRL_EN_BIT] && !en_q);
            if (wr_ctrl) begin
                en_q    <= host_wdata[CTRL_EN_BIT];
                steer_q <= host_wdata[CTRL_STEER_BIT];
            end
        end
    end

    // Sticky flag and interrupt: a status read clears them, and a timeout sets them and wins.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
            irq_q  <= 1'b0;
        end else begin
            if (rd_stat) begin
                flag_q <= 1'b0;
                irq_q  <= 1'b0;
            end
            if (fire) begin
                flag_q <= 1'b1;
                if (!steer_q) irq_q <= 1'b1;
            end
        end
    end

    // Return read data combinationally for the addressed register.
    always_comb begin
        host_rdata = '0;
        unique case (host_addr)
            ADDR_HUND: host_rdata = hund_q;
            ADDR_SECS: host_rdata = secs_q;
            ADDR_STAT: host_rdata[STAT_FLAG_BIT] = flag_q;
            ADDR_CTRL: begin
                host_rdata[CTRL_EN_BIT]    = en_q;
                host_rdata[CTRL_STEER_BIT] = steer_q;
            end
            default: host_rdata = '0;
        endcase
    end

    assign en_o     = en_q;
    assign steer_o  = steer_q;
    assign reload_o = {secs_q, hund_q};
    assign load_o   = load_q;
    assign irq_o    = irq_q;

    // R6
    flag_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fire |=> flag_q);
    // R6
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stat && !fire) |=> !flag_q);
    // R5
    irq_has_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_q |-> flag_q);
    // R2
    stored_bcd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hund_q[3:0] <= 4'd9) && (hund_q[7:4] <= 4'd9) &&
        (secs_q[3:0] <= 4'd9) && (secs_q[7:4] <= 4'd9));
endmodule

// File: rtl/bcd_wdt_counter.sv
// Module: multi-digit BCD down-counter.
// Counts down one step per tick while enabled with a nonzero reload value.
// Raises fire on the tick that would bring the count to zero, and
// reloads on that tick. A load strobe takes priority over a tick.
// Assumes the reload value holds legal BCD digits.
module bcd_wdt_counter #(
    parameter int DIGITS = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic                en,
    input  logic                load,
    input  logic [4*DIGITS-1:0] reload,
    output logic                fire
);
    localparam int CNT_W = 4 * DIGITS;

    logic [3:0] cnt_q  [DIGITS];
    logic [3:0] dec_d  [DIGITS];
    logic       is_last;
    logic       running;

    // Ripple a borrow through the digits and detect a count of 0 or 1.
    always_comb begin
        logic borrow;
        logic upper_zero;
        borrow     = 1'b1;
        upper_zero = 1'b1;
        for (int i = 0; i < DIGITS; i++) begin
            if (borrow && cnt_q[i] == 4'd0) begin
                dec_d[i] = 4'd9;
            end else if (borrow) begin
                dec_d[i] = cnt_q[i] - 4'd1;
                borrow   = 1'b0;
            end else begin
                dec_d[i] = cnt_q[i];
            end
            if (i > 0 && cnt_q[i] != 4'd0) upper_zero = 1'b0;
        end
        is_last = upper_zero && (cnt_q[0] <= 4'd1);
    end

    // The counter runs only when enabled with a nonzero reload value.
    always_comb begin
        running = en && (reload != {CNT_W{1'b0}});
        fire    = tick && running && is_last && !load;
    end

    // Load, reload on expiry, or decrement one step per tick.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DIGITS; i++) cnt_q[i] <= 4'd0;
        end else if (load || fire) begin
            for (int i = 0; i < DIGITS; i++) cnt_q[i] <= reload[4*i +: 4];
        end else if (tick && running) begin
            for (int i = 0; i < DIGITS; i++) cnt_q[i] <= dec_d[i];
        end
    end

    generate
        for (genvar g = 0; g < DIGITS; g++) begin : g_digit_chk
            // R3
            digit_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
                cnt_q[g] <= 4'd9);
        end
    endgenerate

    // R9
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !(tick && running)) |=> $stable(cnt_q[0]));
endmodule

// File: rtl/bcd_wdt_pulse.sv
// Module: fixed-length pulse stretcher.
// A start strobe drives the output high for exactly PULSE_CYCLES
// clock cycles, beginning in the cycle after the strobe.
// A new start during a pulse restarts it.
module bcd_wdt_pulse #(
    parameter int PULSE_CYCLES = 16
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic pulse
);
    localparam int CW = $clog2(PULSE_CYCLES + 1);
    localparam logic [CW-1:0] LEN = CW'(PULSE_CYCLES);

    logic [CW-1:0] remain_q;

    // Count down the remaining pulse length.
    always_ff @(posedge clk) begin
        if (!rst_n)                     remain_q <= '0;
        else if (start)                 remain_q <= LEN;
        else if (remain_q != '0)        remain_q <= remain_q - 1'b1;
    end

    assign pulse = (remain_q != '0);

    // R4
    pulse_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> pulse);
endmodule

// File: rtl/bcd_wdt.sv
// Module: BCD hundredths watchdog timer, top level.
// Joins the register file, the BCD down-counter and the reset pulse
// stretcher. The timeout goes to the reset pulse or the interrupt
// level, chosen by the steering bit.
// Assumes tick_100hz is a one-cycle strobe that is synchronous to clk.
module bcd_wdt
    import bcd_wdt_pkg::*;
#(
    parameter int PULSE_CYCLES = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick_100hz,
    input  logic              host_wr,
    input  logic              host_rd,
    input  logic [ADDR_W-1:0] host_addr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic              wdt_reset,
    output logic              wdt_irq
);
    localparam int DIGITS = (2 * DATA_W) / 4;

    logic                en;
    logic                steer;
    logic [4*DIGITS-1:0] reload;
    logic                load;
    logic                fire;
    logic                pulse_start;

    bcd_wdt_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_wr    (host_wr),
        .host_rd    (host_rd),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .fire       (fire),
        .en_o       (en),
        .steer_o    (steer),
        .reload_o   (reload),
        .load_o     (load),
        .irq_o      (wdt_irq)
    );

    bcd_wdt_counter #(.DIGITS(DIGITS)) u_counter (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick   (tick_100hz),
        .en     (en),
        .load   (load),
        .reload (reload),
        .fire   (fire)
    );

    // Send the timeout to the reset pulse only when steering is set.
    assign pulse_start = fire && steer;

    bcd_wdt_pulse #(.PULSE_CYCLES(PULSE_CYCLES)) u_pulse (
        .clk   (clk),
        .rst_n (rst_n),
        .start (pulse_start),
        .pulse (wdt_reset)
    );

    // R4
    reset_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wdt_reset) |-> $past(fire && steer));
    // R5
    irq_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wdt_irq) |-> $past(fire && !steer));
endmodule

// File: tb/bcd_wdt_bench.sv
module bcd_wdt_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick_100hz = 1'b0;
    logic       host_wr = 1'b0;
    logic       host_rd = 1'b0;
    logic [3:0] host_addr = 4'h0;
    logic [7:0] host_wdata = 8'h00;
    logic [7:0] host_rdata;
    logic       wdt_reset;
    logic       wdt_irq;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    bcd_wdt u_bcd_wdt (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick_100hz (tick_100hz),
        .host_wr    (host_wr),
        .host_rd    (host_rd),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_rdata (host_rdata),
        .wdt_reset  (wdt_reset),
        .wdt_irq    (wdt_irq)
    );

    // Each vector: {seconds BCD, hundredths BCD, steer}
    localparam logic [16:0] VECS [0:6] = '{
        {8'h00, 8'h01, 1'b0},
        {8'h00, 8'h10, 1'b1},
        {8'h01, 8'h00, 1'b0},
        {8'h00, 8'h99, 1'b1},
        {8'h02, 8'h05, 1'b0},
        {8'h10, 8'h00, 1'b1},
        {8'h99, 8'h99, 1'b0}
    };

    function automatic int bcd_ticks(input logic [7:0] s, input logic [7:0] h);
        return (s[7:4] * 1000) + (s[3:0] * 100) + (h[7:4] * 10) + h[3:0];
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] a, input logic [7:0] d);
        @(negedge clk);
        host_wr = 1'b1; host_addr = a; host_wdata = d;
        @(negedge clk);
        host_wr = 1'b0;
    endtask

    task automatic rd(input logic [3:0] a, output logic [7:0] d);
        @(negedge clk);
        host_rd = 1'b1; host_addr = a;
        #1 d = host_rdata;
        @(negedge clk);
        host_rd = 1'b0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            tick_100hz = 1'b1;
            @(negedge clk);
            tick_100hz = 1'b0;
        end
    endtask

    task automatic read_flag(input string req, input int exp);
        logic [7:0] d;
        rd(4'hE, d);
        check(req, int'(d), exp ? 2 : 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        int n;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        for (int a = 12; a < 16; a++) begin
            rd(4'(a), d);
            check("R1 reset reg", int'(d), 0);
        end
        check("R1 reset outputs", int'({wdt_reset, wdt_irq}), 0);

        // Main table
        for (int v = 0; v < 7; v++) begin
            n = bcd_ticks(VECS[v][16:9], VECS[v][8:1]);
            wr(4'hC, VECS[v][8:1]);
            wr(4'hD, VECS[v][16:9]);
            wr(4'hF, {6'b0, 1'b1, VECS[v][0]});
            rd(4'hD, d);
            check("R1 secs readback", int'(d), int'(VECS[v][16:9]));
            rd(4'hF, d);
            check("R1 ctrl readback", int'(d), 2 + int'(VECS[v][0]));
            ticks(n - 1);
            read_flag("R3 no early timeout", 0);
            ticks(1);
            if (VECS[v][0]) begin
                check("R4 reset on steer", int'({wdt_reset, wdt_irq}), 2);
                for (int c = 1; c < 16; c++) begin
                    @(negedge clk);
                    check("R4 pulse held", int'(wdt_reset), 1);
                end
                @(negedge clk);
                check("R4 pulse ends at 16", int'(wdt_reset), 0);
            end else begin
                check("R5 irq on no steer", int'({wdt_reset, wdt_irq}), 1);
                repeat (20) @(negedge clk);
                check("R5 irq held", int'({wdt_reset, wdt_irq}), 1);
            end
            read_flag("R6 flag set", 1);
            read_flag("R6 flag cleared", 0);
            check("R6 irq cleared", int'(wdt_irq), 0);
            wr(4'hF, 8'h00);
        end

        // R2 clamp of nibbles above 9
        wr(4'hC, 8'hAF);
        rd(4'hC, d);
        check("R2 clamp", int'(d), 8'h99);

        // R11 status write ignored
        wr(4'hE, 8'hFF);
        read_flag("R11 status write ignored", 0);

        // R7 kick and R8 reload
        wr(4'hD, 8'h00);
        wr(4'hC, 8'h10);
        wr(4'hF, 8'h02);
        ticks(6);
        wr(4'hC, 8'h10);
        ticks(9);
        read_flag("R7 kick restarts count", 0);
        ticks(1);
        check("R7 timeout after kick", int'(wdt_irq), 1);
        read_flag("R7 flag", 1);
        ticks(9);
        read_flag("R8 no early second timeout", 0);
        ticks(1);
        read_flag("R8 second timeout", 1);

        // R9 disabled ticks ignored, enable rise reloads
        wr(4'hC, 8'h05);
        ticks(3);
        wr(4'hF, 8'h00);
        ticks(20);
        read_flag("R9 disabled ignores ticks", 0);
        wr(4'hF, 8'h02);
        ticks(4);
        read_flag("R9 enable reloads", 0);
        ticks(1);
        read_flag("R9 timeout after reload", 1);

        // R6 timeout in the same cycle as a status read
        wr(4'hC, 8'h01);
        ticks(1);
        @(negedge clk);
        host_rd = 1'b1; host_addr = 4'hE; tick_100hz = 1'b1;
        #1 check("R6 read returns flag", int'(host_rdata), 2);
        @(negedge clk);
        host_rd = 1'b0; tick_100hz = 1'b0;
        read_flag("R6 timeout wins over clear", 1);
        wr(4'hF, 8'h00);

        // R10 zero value never fires
        wr(4'hC, 8'h00);
        wr(4'hD, 8'h00);
        wr(4'hF, 8'h03);
        ticks(30);
        check("R10 zero no reset", int'({wdt_reset, wdt_irq}), 0);
        read_flag("R10 zero no flag", 0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule